// File: doc/BRIEF.md
# Program Counter with Page-Carry Stall

This block holds the fetch address of a small 8-bit core and moves it forward as instructions retire. The sequencer asks for an advance together with the byte length of the instruction just executed, or asks for a jump with a full target address. The block drives the current fetch address and a busy flag back to the sequencer.

The address is kept as a page byte (upper) and an offset byte (lower). A sequential advance only adds into the offset byte in its own cycle. When that addition carries out of the offset byte, the page byte is incremented in one extra cycle, and busy is high during that cycle. A jump writes both bytes at once and never costs the extra cycle, wherever the target lands.

Top module: `pc_seq`

## Requirements
- R1: While rst_n is low and after its release, pc reads 0x0000 and busy reads 0.
- R2: An advance (adv_req=1, jmp_req=0, busy=0) whose sum stays inside the current 256-byte page shows pc = old pc + adv_len after the next rising edge, with busy 0. adv_len is a 2-bit unsigned byte count; values 1, 2 and 3 are meant for instructions.
- R3: An advance whose sum carries out of the low byte (bits 7:0) shows, after the next edge, the new low byte with the old upper byte and busy 1. After the edge that follows, pc equals the full sum and busy is 0.
- R4: A jump (jmp_req=1) shows pc = jmp_tgt after the next edge with busy 0, including when the target lies in another page.
- R5: When jmp_req and adv_req are both high in one cycle, the jump wins and adv_len has no effect on pc.
- R6: An advance request presented while busy is 1 is ignored: pc after the busy cycle is only the page increment.
- R7: A jump presented while busy is 1 loads jmp_tgt, clears busy, and drops the pending page increment.
- R8: A sequential advance past 0xFFFF wraps to the bottom of the space (0xFFFE + 3 gives 0xFF01 then 0x0001).
- R9: An advance with adv_len = 0 leaves pc unchanged and busy 0.
- R10: With neither request high and busy 0, pc holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_req | input | 1 | Advance by adv_len bytes |
| adv_len | input | LEN_W (2) | Byte length of the retired instruction |
| jmp_req | input | 1 | Load jmp_tgt into pc |
| jmp_tgt | input | PC_W (16) | Jump target address |
| pc | output | PC_W (16) | Current fetch address |
| busy | output | 1 | High during the page-carry cycle |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit pages and a 2-bit length. With those values a jump can place pc one to three bytes below any page edge, so every carry case, the top-of-space wrap and the collisions of jumps and advances with the busy cycle are reached in a few cycles each, without walking through the address space.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_req,
  input  logic [LEN_W-1:0] adv_len,
  input  logic             jmp_req,
  input  logic [PC_W-1:0]  jmp_tgt,
  output logic [PC_W-1:0]  pc,
  output logic             busy
);
  localparam int HI_W = PC_W - PAGE_W;

  logic [PAGE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              busy_q;
  logic [PAGE_W:0]   lo_sum;

  assign lo_sum = {1'b0, lo_q} + (PAGE_W+1)'(adv_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      busy_q <= 1'b0;
    end else if (jmp_req) begin
      lo_q   <= jmp_tgt[PAGE_W-1:0];
      hi_q   <= jmp_tgt[PC_W-1:PAGE_W];
      busy_q <= 1'b0;
    end else if (busy_q) begin
      hi_q   <= hi_q + HI_W'(1);
      busy_q <= 1'b0;
    end else if (adv_req) begin
      lo_q   <= lo_sum[PAGE_W-1:0];
      busy_q <= lo_sum[PAGE_W];
    end
  end

  assign pc   = {hi_q, lo_q};
  assign busy = busy_q;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_req,
  input logic [LEN_W-1:0] adv_len,
  input logic             jmp_req,
  input logic [PC_W-1:0]  jmp_tgt,
  input logic [PC_W-1:0]  pc,
  input logic             busy
);
  logic [PAGE_W:0] ofs_add;
  logic            go;
  assign ofs_add = {1'b0, pc[PAGE_W-1:0]} + (PAGE_W+1)'(adv_len);
  assign go      = adv_req && !jmp_req && !busy;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> pc == '0 && !busy);

  p_adv_in_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go && !ofs_add[PAGE_W] |=> !busy && pc == $past(pc) + PC_W'($past(adv_len)));

  p_carry_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go && ofs_add[PAGE_W] |=> busy && pc[PAGE_W-1:0] == $past(ofs_add[PAGE_W-1:0])
                              && pc[PC_W-1:PAGE_W] == $past(pc[PC_W-1:PAGE_W]));

  p_carry_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !jmp_req |=> !busy && pc == $past(pc) + PC_W'(1 << PAGE_W));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_req |=> !busy && pc == $past(jmp_tgt));

  p_no_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go && adv_len == '0 |=> $stable(pc) && !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_req && !jmp_req && !busy |=> $stable(pc) && !busy);
endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_pc_seq.sv
`timescale 1ns/1ps
module sim_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_req = 1'b0;
  logic [1:0]  adv_len = '0;
  logic        jmp_req = 1'b0;
  logic [15:0] jmp_tgt = '0;
  logic [15:0] pc;
  logic        busy;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pc_seq u0 (.clk(clk), .rst_n(rst_n), .adv_req(adv_req), .adv_len(adv_len),
             .jmp_req(jmp_req), .jmp_tgt(jmp_tgt), .pc(pc), .busy(busy));

  task automatic cyc(input logic a, input logic [1:0] l, input logic j, input logic [15:0] t);
    @(negedge clk);
    adv_req = a; adv_len = l; jmp_req = j; jmp_tgt = t;
    @(posedge clk);
    #1;
    adv_req = 1'b0; adv_len = '0; jmp_req = 1'b0; jmp_tgt = '0;
  endtask

  task automatic chk(input string tag, input logic [15:0] exp_pc, input logic exp_busy);
    checks++;
    if (pc !== exp_pc || busy !== exp_busy) begin
      failures++;
      $display("FAIL %s: pc=%h busy=%b expected pc=%h busy=%b", tag, pc, busy, exp_pc, exp_busy);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R1 in reset", 16'h0000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 after release", 16'h0000, 1'b0);
  endtask

  task automatic t_in_page;
    cyc(0, 0, 1, 16'h1234); chk("R4 jump", 16'h1234, 0);
    cyc(1, 1, 0, 0);        chk("R2 len1", 16'h1235, 0);
    cyc(1, 2, 0, 0);        chk("R2 len2", 16'h1237, 0);
    cyc(1, 3, 0, 0);        chk("R2 len3", 16'h123A, 0);
  endtask

  task automatic t_carry;
    cyc(0, 0, 1, 16'h12FE);
    cyc(1, 3, 0, 0); chk("R3 carry first", 16'h1201, 1);
    cyc(0, 0, 0, 0); chk("R3 carry done", 16'h1301, 0);
  endtask

  task automatic t_busy_adv;
    cyc(0, 0, 1, 16'h20FF);
    cyc(1, 1, 0, 0); chk("R3 edge len1", 16'h2000, 1);
    cyc(1, 3, 0, 0); chk("R6 adv in busy", 16'h2100, 0);
    cyc(0, 0, 0, 0); chk("R10 hold", 16'h2100, 0);
    cyc(0, 0, 0, 0); chk("R10 hold 2", 16'h2100, 0);
  endtask

  task automatic t_jumps;
    cyc(0, 0, 1, 16'h30FF);
    cyc(0, 0, 1, 16'h3100); chk("R4 cross page jump", 16'h3100, 0);
    cyc(1, 2, 1, 16'h4000); chk("R5 jump wins", 16'h4000, 0);
    cyc(0, 0, 0, 0);        chk("R5 no late advance", 16'h4000, 0);
  endtask

  task automatic t_busy_jump;
    cyc(0, 0, 1, 16'h50FF);
    cyc(1, 1, 0, 0);        chk("R7 setup", 16'h5000, 1);
    cyc(1, 2, 1, 16'h6000); chk("R7 jump in busy", 16'h6000, 0);
    cyc(0, 0, 0, 0);        chk("R7 no page step", 16'h6000, 0);
  endtask

  task automatic t_wrap;
    cyc(0, 0, 1, 16'hFFFE);
    cyc(1, 3, 0, 0); chk("R8 wrap first", 16'hFF01, 1);
    cyc(0, 0, 0, 0); chk("R8 wrap done", 16'h0001, 0);
  endtask

  task automatic t_zero;
    cyc(0, 0, 1, 16'h77FF);
    cyc(1, 0, 0, 0); chk("R9 len0", 16'h77FF, 0);
  endtask

  initial begin
    t_reset;
    t_in_page;
    t_carry;
    t_busy_adv;
    t_jumps;
    t_busy_jump;
    t_wrap;
    t_zero;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule